// File: doc/BRIEF.md
# Address-Event Spike Router with Burst Expansion

This block sits between an array of spiking neurons and the shared address-event bus that feeds the array. Each time a neuron fires, the array hands the block the neuron's 6-bit address. The block looks that address up in a programmable routing table and replays the matching list of target events back towards the array. Each event carries a 6-bit target address and a synapse-type bit. Synaptic strength is expressed by repetition. A target that appears k times in a source's list receives a burst of k identical events.

A winner-take-all arrangement is built from such lists. One firing neuron expands into three parts: a burst of inhibitory events back to itself, which resets its membrane to a defined level; inhibitory events to every competitor; and a burst of excitatory events to itself. Source spikes that arrive while a burst is still going out wait in a small FIFO. A host can also inject single events directly, for example from a stored stimulus list. Every accepted source spike is also mirrored to a monitor output.

Output events leave through a four-phase request/acknowledge handshake. The acknowledge from the array is active low.

Top module: `spk_router`

## Requirements
- R1: After reset, `ev_req` and `mon_valid` are low and `src_ready` is high. The start/length entry of every source reads as length zero.
- R2: A source spike from address s emits the entries at table positions start(s), start(s)+1, ..., start(s)+len(s)-1, in that order. Each event presents the entry's address on `ev_addr` and its type on `ev_inh` (1 = inhibitory, 0 = excitatory).
- R3: Each table entry is emitted as its own event, so a repeated entry forms a burst of identical events. A source whose length is zero emits no event at all.
- R4: `ev_addr` and `ev_inh` stay constant while `ev_req` is high. `ev_req` falls on the cycle after `ev_ack_n` is seen low, and it does not rise again while `ev_ack_n` is still low.
- R5: Source spikes that arrive during a burst are held in a FIFO of FIFO_DEPTH entries and served in arrival order, with none lost. `src_ready` is low exactly while that FIFO is full.
- R6: An injected event (`ext_valid`, `ext_addr`, `ext_inh`) goes out unchanged as a single event, with `ev_req` rising the cycle after `ext_ready`. Injection never splits a burst. Between bursts it takes precedence over queued source spikes.
- R7: Each accepted source spike appears on `mon_valid`/`mon_addr` for exactly one cycle, on the cycle after acceptance.
- R8: `cfg_we` with `cfg_sel`=0 writes the start/length entry of source `cfg_addr[5:0]`, with start in `cfg_wdata[7:0]` and length in `cfg_wdata[15:8]`. With `cfg_sel`=1 it writes the table entry `cfg_addr`, with address in `cfg_wdata[5:0]` and type in `cfg_wdata[6]`. Writes take effect for spikes accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source spike present |
| src_addr | input | 6 | Address of the firing neuron |
| src_ready | output | 1 | Source FIFO can accept a spike |
| mon_valid | output | 1 | Mirror pulse of an accepted source spike |
| mon_addr | output | 6 | Mirrored source address |
| ext_valid | input | 1 | Injected event present |
| ext_addr | input | 6 | Injected event target address |
| ext_inh | input | 1 | Injected event type (1 = inhibitory) |
| ext_ready | output | 1 | Injected event taken this cycle |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 = start/length entry, 1 = table entry |
| cfg_addr | input | 8 | Source or entry index |
| cfg_wdata | input | 16 | Write data |
| ev_req | output | 1 | Output event request |
| ev_addr | output | 6 | Output event target address |
| ev_inh | output | 1 | Output event type (1 = inhibitory) |
| ev_ack_n | input | 1 | Active-low acknowledge from the array |

## Verification
Some properties are checked on every cycle: that the output event stays still under a raised request, that the request is released after the acknowledge, that FIFO occupancy follows pushes and pops, that the monitor mirrors each accepted spike, and that an accepted injection appears on the bus one cycle later. Other behaviour only the bench scenarios can show: the content and order of each expanded list, bursts of repeated entries, silence from an empty source, the service order of queued spikes against an injection, back-pressure when the FIFO fills, and the effect of rewriting the tables.

// File: rtl/spk_route_pkg.sv
package spk_route_pkg;

    localparam int ADDR_W = 6;
    localparam int N_SRC  = 1 << ADDR_W;
    localparam int ENT_W  = 8;
    localparam int N_ENT  = 1 << ENT_W;
    localparam int CNT_W  = 8;
    localparam int CFG_DW = CNT_W + ENT_W;

    typedef struct packed {
        logic              inh;
        logic [ADDR_W-1:0] addr;
    } spk_evt_t;

    typedef struct packed {
        logic [CNT_W-1:0] len;
        logic [ENT_W-1:0] start;
    } route_ptr_t;

    typedef enum logic {
        SEL_PTR = 1'b0,
        SEL_ENT = 1'b1
    } cfg_sel_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_REQ,
        TX_REL
    } tx_state_e;

    typedef enum logic {
        EX_IDLE,
        EX_BURST
    } ex_state_e;

    function automatic spk_evt_t word_to_evt(input logic [CFG_DW-1:0] w);
        return spk_evt_t'(w[ADDR_W:0]);
    endfunction

    function automatic route_ptr_t word_to_ptr(input logic [CFG_DW-1:0] w);
        return route_ptr_t'(w);
    endfunction

endpackage

// File: rtl/spk_src_fifo.sv
module spk_src_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [OCC_W-1:0] occ;
    logic             do_push, do_pop;

    assign empty   = (occ == '0);
    assign full    = (occ == OCC_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    a_r5_push_counts: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (occ == $past(occ) + 1'b1));
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));

endmodule

// File: rtl/spk_route_table.sv
module spk_route_table
    import spk_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ENT_W-1:0]  cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] ptr_raddr,
    output route_ptr_t        ptr_rd,
    input  logic [ENT_W-1:0]  ent_raddr,
    output spk_evt_t          ent_rd
);
    route_ptr_t ptr_mem [N_SRC];
    spk_evt_t   ent_mem [N_ENT];

    logic ptr_we, ent_we;
    assign ptr_we = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_PTR);
    assign ent_we = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_ENT);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SRC; i++) ptr_mem[i] <= '0;
        end else if (ptr_we) begin
            ptr_mem[cfg_addr[ADDR_W-1:0]] <= word_to_ptr(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (ent_we) ent_mem[cfg_addr] <= word_to_evt(cfg_wdata);
    end

    assign ptr_rd = ptr_mem[ptr_raddr];
    assign ent_rd = ent_mem[ent_raddr];

endmodule

// File: rtl/spk_burst_seq.sv
module spk_burst_seq
    import spk_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_empty,
    output logic             fifo_pop,
    input  route_ptr_t       ptr_rd,
    input  spk_evt_t         ent_rd,
    output logic [ENT_W-1:0] ent_idx,
    input  logic             ext_valid,
    input  spk_evt_t         ext_evt,
    output logic             ext_ready,
    input  logic             tx_ready,
    output logic             out_valid,
    output spk_evt_t         out_evt
);
    ex_state_e        state;
    logic [ENT_W-1:0] idx;
    logic [CNT_W-1:0] remain;

    assign ent_idx = idx;

    always_comb begin
        fifo_pop  = 1'b0;
        ext_ready = 1'b0;
        out_valid = 1'b0;
        out_evt   = ent_rd;
        case (state)
            EX_IDLE: begin
                if (ext_valid) begin
                    out_valid = 1'b1;
                    out_evt   = ext_evt;
                    ext_ready = tx_ready;
                end else begin
                    fifo_pop = !fifo_empty;
                end
            end
            default: out_valid = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= EX_IDLE;
            idx    <= '0;
            remain <= '0;
        end else begin
            case (state)
                EX_IDLE: begin
                    if (fifo_pop) begin
                        idx    <= ptr_rd.start;
                        remain <= ptr_rd.len;
                        if (ptr_rd.len != '0) state <= EX_BURST;
                    end
                end
                default: begin
                    if (tx_ready) begin
                        idx    <= idx + 1'b1;
                        remain <= remain - 1'b1;
                        if (remain == CNT_W'(1)) state <= EX_IDLE;
                    end
                end
            endcase
        end
    end

    a_r3_burst_nonempty: assert property (@(posedge clk) disable iff (rst)
        (state == EX_BURST) |-> (remain != '0));

endmodule

// File: rtl/spk_aer_tx.sv
module spk_aer_tx
    import spk_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  spk_evt_t          in_evt,
    output logic              in_ready,
    output logic              ev_req,
    output logic [ADDR_W-1:0] ev_addr,
    output logic              ev_inh,
    input  logic              ev_ack_n
);
    tx_state_e state;
    spk_evt_t  held;

    assign in_ready = (state == TX_IDLE);
    assign ev_req   = (state == TX_REQ);
    assign ev_addr  = held.addr;
    assign ev_inh   = held.inh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            held  <= '0;
        end else begin
            case (state)
                TX_IDLE: if (in_valid) begin
                    held  <= in_evt;
                    state <= TX_REQ;
                end
                TX_REQ:  if (!ev_ack_n) state <= TX_REL;
                default: if (ev_ack_n)  state <= TX_IDLE;
            endcase
        end
    end

    a_r4_data_stable: assert property (@(posedge clk) disable iff (rst)
        (ev_req && $past(ev_req)) |-> ($stable(ev_addr) && $stable(ev_inh)));
    a_r4_release: assert property (@(posedge clk) disable iff (rst)
        (ev_req && !ev_ack_n) |=> !ev_req);
    a_r4_wait_ack_high: assert property (@(posedge clk) disable iff (rst)
        (!ev_req && $past(ev_req) && !ev_ack_n) |=> !ev_req);

endmodule

// File: rtl/spk_router.sv
module spk_router
    import spk_route_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [ADDR_W-1:0] src_addr,
    output logic              src_ready,
    output logic              mon_valid,
    output logic [ADDR_W-1:0] mon_addr,
    input  logic              ext_valid,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ext_inh,
    output logic              ext_ready,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ENT_W-1:0]  cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              ev_req,
    output logic [ADDR_W-1:0] ev_addr,
    output logic              ev_inh,
    input  logic              ev_ack_n
);
    logic              fifo_empty, fifo_full, fifo_pop;
    logic [ADDR_W-1:0] fifo_head;
    route_ptr_t        ptr_rd;
    spk_evt_t          ent_rd, ext_evt, seq_evt;
    logic [ENT_W-1:0]  ent_idx;
    logic              seq_valid, tx_ready;

    assign src_ready = !fifo_full;
    assign ext_evt   = '{inh: ext_inh, addr: ext_addr};

    spk_src_fifo #(.DEPTH(FIFO_DEPTH), .W(ADDR_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push(src_valid), .push_data(src_addr),
        .pop(fifo_pop), .head(fifo_head),
        .empty(fifo_empty), .full(fifo_full)
    );

    spk_route_table u_table (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ptr_raddr(fifo_head), .ptr_rd(ptr_rd),
        .ent_raddr(ent_idx), .ent_rd(ent_rd)
    );

    spk_burst_seq u_seq (
        .clk(clk), .rst(rst),
        .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .ptr_rd(ptr_rd), .ent_rd(ent_rd), .ent_idx(ent_idx),
        .ext_valid(ext_valid), .ext_evt(ext_evt), .ext_ready(ext_ready),
        .tx_ready(tx_ready), .out_valid(seq_valid), .out_evt(seq_evt)
    );

    spk_aer_tx u_tx (
        .clk(clk), .rst(rst),
        .in_valid(seq_valid), .in_evt(seq_evt), .in_ready(tx_ready),
        .ev_req(ev_req), .ev_addr(ev_addr), .ev_inh(ev_inh), .ev_ack_n(ev_ack_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_valid <= 1'b0;
            mon_addr  <= '0;
        end else begin
            mon_valid <= src_valid && src_ready;
            if (src_valid && src_ready) mon_addr <= src_addr;
        end
    end

    a_r7_mirror: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready) |=> (mon_valid && mon_addr == $past(src_addr)));
    a_r6_inject_out: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && ext_ready) |=>
            (ev_req && ev_addr == $past(ext_addr) && ev_inh == $past(ext_inh)));

endmodule

// File: tb/tb_spk_router.sv
module tb_spk_router;
    import spk_route_pkg::*;

    logic clk = 0, rst = 1;
    logic src_valid = 0; logic [5:0] src_addr = 0;
    logic src_ready, mon_valid; logic [5:0] mon_addr;
    logic ext_valid = 0; logic [5:0] ext_addr = 0; logic ext_inh = 0; logic ext_ready;
    logic cfg_we = 0, cfg_sel = 0; logic [7:0] cfg_addr = 0; logic [15:0] cfg_wdata = 0;
    logic ev_req, ev_inh; logic [5:0] ev_addr; logic ev_ack_n = 1;

    always #5 clk = ~clk;

    spk_router dut (.*);

    int checks = 0, errors = 0, seen = 0;
    bit done = 0;
    string phase = "R2";
    logic [6:0] exp_q [$];
    logic [7:0] m_start [64];
    logic [7:0] m_len [64];
    logic [6:0] m_ent [256];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_ptr(input int s, input int start, input int len);
        @(negedge clk); cfg_we = 1; cfg_sel = 0; cfg_addr = 8'(s); cfg_wdata = {8'(len), 8'(start)};
        @(negedge clk); cfg_we = 0;
        m_start[s] = 8'(start); m_len[s] = 8'(len);
    endtask

    task automatic wr_ent(input int e, input int a, input bit inh);
        @(negedge clk); cfg_we = 1; cfg_sel = 1; cfg_addr = 8'(e); cfg_wdata = 16'({inh, 6'(a)});
        @(negedge clk); cfg_we = 0;
        m_ent[e] = {inh, 6'(a)};
    endtask

    task automatic expect_src(input int s);
        for (int k = 0; k < int'(m_len[s]); k++) exp_q.push_back(m_ent[8'(int'(m_start[s]) + k)]);
    endtask

    task automatic drive_spike(input int s);
        @(negedge clk); src_valid = 1; src_addr = 6'(s);
        forever begin #1; if (src_ready) break; @(negedge clk); end
        @(negedge clk);
        chk(mon_valid == 1'b1 && mon_addr == 6'(s), "R7", "monitor mirror", int'(mon_addr), s);
        src_valid = 0;
    endtask

    task automatic inject(input int a, input bit inh);
        @(negedge clk); ext_valid = 1; ext_addr = 6'(a); ext_inh = inh;
        forever begin #1; if (ext_ready) break; @(negedge clk); end
        @(negedge clk); ext_valid = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    // array model: active-low acknowledge, scoreboard monitor
    initial begin
        int lat = 1;
        forever begin
            @(negedge clk);
            if (ev_req && ev_ack_n) begin
                logic [6:0] got, exp;
                got = {ev_inh, ev_addr};
                repeat (lat) @(negedge clk);
                chk({ev_inh, ev_addr} == got && ev_req, "R4", "event held under request", int'({ev_inh, ev_addr}), int'(got));
                seen++;
                if (exp_q.size() == 0) chk(0, phase, "unexpected event", int'(got), -1);
                else begin
                    exp = exp_q.pop_front();
                    chk(got == exp, phase, "event", int'(got), int'(exp));
                end
                ev_ack_n = 0;
                @(negedge clk);
                chk(!ev_req, "R4", "request released after ack", int'(ev_req), 0);
                repeat (lat) begin
                    @(negedge clk);
                    chk(!ev_req, "R4", "no request while ack low", int'(ev_req), 0);
                end
                ev_ack_n = 1;
                lat = lat % 3 + 1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog phase %s actual=%0d expected=%0d", phase, exp_q.size(), 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0;
        for (int i = 0; i < 64; i++) begin m_start[i] = 0; m_len[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(ev_req == 0, "R1", "ev_req after reset", int'(ev_req), 0);
        chk(src_ready == 1, "R1", "src_ready after reset", int'(src_ready), 1);
        chk(mon_valid == 0, "R1", "mon_valid after reset", int'(mon_valid), 0);

        // R1: unprogrammed source emits nothing
        phase = "R1"; s0 = seen;
        drive_spike(17); repeat (20) @(negedge clk);
        chk(seen == s0, "R1", "unprogrammed source silent", seen - s0, 0);

        // winner-take-all list for source 5: reset burst, competitors, self-excitation
        wr_ent(0, 5, 1); wr_ent(1, 5, 1); wr_ent(2, 5, 1);
        wr_ent(3, 1, 1); wr_ent(4, 2, 1);
        wr_ent(5, 5, 0); wr_ent(6, 5, 0);
        wr_ptr(5, 0, 7);
        wr_ent(10, 12, 0); wr_ent(11, 12, 0); wr_ptr(9, 10, 2);
        wr_ent(20, 63, 1); wr_ptr(20, 20, 1);
        wr_ptr(30, 0, 0);
        for (int k = 0; k < 6; k++) wr_ent(40 + k, 40 + k, k[0]);
        wr_ptr(40, 40, 6);

        phase = "R2"; expect_src(5); drive_spike(5); drain();
        phase = "R5"; expect_src(9); expect_src(20); drive_spike(9); drive_spike(20); drain();

        phase = "R3"; s0 = seen; drive_spike(30); repeat (25) @(negedge clk);
        chk(seen == s0, "R3", "zero-length source silent", seen - s0, 0);

        phase = "R6"; exp_q.push_back({1'b0, 6'd33}); inject(33, 0); drain();

        // R6: injection waits for the burst, then beats the queued spike
        phase = "R6";
        expect_src(40); exp_q.push_back({1'b1, 6'd50}); expect_src(9);
        drive_spike(40); drive_spike(9); inject(50, 1); drain();

        // R5: FIFO fills and back-pressures
        phase = "R5";
        for (int k = 0; k < 5; k++) expect_src(40);
        for (int k = 0; k < 5; k++) drive_spike(40);
        #1; chk(src_ready == 0, "R5", "src_ready low when full", int'(src_ready), 0);
        drain();
        chk(src_ready == 1, "R5", "src_ready back after drain", int'(src_ready), 1);

        // R8: rewrite tables
        phase = "R8";
        wr_ent(20, 7, 0); wr_ptr(9, 20, 1);
        expect_src(9); drive_spike(9); drain();
        chk(seen > 0, "R8", "events observed", seen, 1);

        chk(exp_q.size() == 0, "R2", "scoreboard empty", exp_q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule